// File: doc/BRIEF.md
# Registered Four-Port Bus Exchanger

The exchanger links four equal-width ports, numbered 0 to 3. Ports 0 and 1 form the left pair and ports 2 and 3 the right pair. A 5-bit route code is stored in a routing register. That code sets up none, one or two port-to-port transfers at the same time. Each port has its own output register, and that register takes data from one of the other three ports on a clock edge. Each port is given as three separate signals: an input data word, an output data word and an output enable. There are no internal tri-states, so the pad drivers sit outside the block.

The `data_mode` input picks what a rising clock edge does. When it is low, the edge loads a new route code. When it is high, the edge moves data along the stored route. The asynchronous active-high `force_off` input disables every port at once and clears the route. The block has two states. In `RT_IDLE` no port drives. In `RT_ACTIVE` a valid route is stored and its destination ports drive.

The state transitions are:
- `IDLE->ACTIVE`: a route load with a valid code.
- `ACTIVE->IDLE`: a route load with an off or unused code.
- `ANY->IDLE`: `force_off` is high.
- All other cases hold the current state.

Top module: `bus_exchanger4`

## Requirements
- R1: While `force_off` is high, `port_oe` is 0 and every output register reads 0. This takes effect immediately, with no clock edge needed.
- R2: A rising edge with `data_mode` low and `force_off` low stores `route_sel`. After that edge, `port_oe` shows the destination ports of the stored code (bit i is port i).
- R3: A rising edge with `data_mode` high captures data into each enabled destination port's output register, taken from the input of its source port. The new value is on `port_out` after that edge.
- R4: While `data_mode` is low, no output register changes.
- R5: A port that is not a destination of the stored route keeps `port_oe` low, and its output register keeps its value through data edges.
- R6: Any code whose top two bits are 00 is treated as all-off. After such a code is loaded, `port_oe` is 0 and data edges change no output register.
- R7: Codes 01xxx route within each pair. The low three bits select the transfers as follows:
  - 000: 1→0 and 2→3
  - 001: 1→0
  - 010: 3→2
  - 011: 1→0 and 3→2
  - 100: 0→1 and 2→3
  - 101: 0→1
  - 110: 2→3
  - 111: 0→1 and 3→2
- R8: Codes 10xxx route between port 0 and port 2, and between port 1 and port 3. The low three bits select the transfers as follows:
  - 000: 0→2 and 3→1
  - 001: 0→2
  - 010: 1→3
  - 011: 0→2 and 1→3
  - 100: 2→0 and 1→3
  - 101: 2→0
  - 110: 3→1
  - 111: 2→0 and 3→1
- R9: Codes 11xxx route between port 0 and port 3, and between port 1 and port 2. The low three bits select the transfers as follows:
  - 000: 3→0 and 1→2
  - 001: 2→1
  - 010: 3→0
  - 011: 3→0 and 2→1
  - 100: 0→3 and 2→1
  - 101: 0→3
  - 110: 1→2
  - 111: 0→3 and 1→2
- R10: After `force_off` is released, `port_oe` stays 0 through data edges. It is enabled again only by a route-load edge.
- R11: While `data_mode` is high, changes on `route_sel` have no effect on `port_oe` or on which ports receive data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| force_off | input | 1 | Asynchronous disable; also clears the route and the output registers |
| data_mode | input | 1 | 0: an edge loads the route; 1: an edge moves data |
| route_sel | input | 5 | Route code |
| port_in | input | 4*W | Input data; port i is bits [i*W +: W] |
| port_out | output | 4*W | Output registers; port i is bits [i*W +: W] |
| port_oe | output | 4 | Output enable for each port |

## Verification
The bench loads all 32 route codes with W=9 and runs two data edges after each load. It compares the enables and all four output words against a transfer list that it holds for each code. Per-port data patterns that differ for each port and each edge show whether a wrong source was picked. Unchanged values on ports that are not destinations show whether an extra capture happened. During the data edges, `route_sel` is driven with the complement of the loaded code; this shows whether the route can change outside load edges. A `force_off` pulse between two edges, followed by data edges, shows whether outputs are disabled immediately and whether enabling again needs a route load.

// File: rtl/xchg_pkg.sv
package xchg_pkg;
    localparam int N_PORT = 4;
    localparam int SRC_W  = $clog2(N_PORT);
    localparam int CODE_W = 5;

    typedef enum logic {
        RT_IDLE   = 1'b0,
        RT_ACTIVE = 1'b1
    } route_state_e;

    typedef struct packed {
        logic [N_PORT-1:0]            en;
        logic [N_PORT-1:0][SRC_W-1:0] src;
    } route_dec_t;
endpackage

// File: rtl/xchg_route_decoder.sv
module xchg_route_decoder
    import xchg_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output route_dec_t        dec
);
    always_comb begin
        dec = '0;
        case (code)
            5'b01000: begin dec.en[0] = 1'b1; dec.src[0] = 2'd1; dec.en[3] = 1'b1; dec.src[3] = 2'd2; end
            5'b01001: begin dec.en[0] = 1'b1; dec.src[0] = 2'd1; end
            5'b01010: begin dec.en[2] = 1'b1; dec.src[2] = 2'd3; end
            5'b01011: begin dec.en[0] = 1'b1; dec.src[0] = 2'd1; dec.en[2] = 1'b1; dec.src[2] = 2'd3; end
            5'b01100: begin dec.en[1] = 1'b1; dec.src[1] = 2'd0; dec.en[3] = 1'b1; dec.src[3] = 2'd2; end
            5'b01101: begin dec.en[1] = 1'b1; dec.src[1] = 2'd0; end
            5'b01110: begin dec.en[3] = 1'b1; dec.src[3] = 2'd2; end
            5'b01111: begin dec.en[1] = 1'b1; dec.src[1] = 2'd0; dec.en[2] = 1'b1; dec.src[2] = 2'd3; end
            5'b10000: begin dec.en[2] = 1'b1; dec.src[2] = 2'd0; dec.en[1] = 1'b1; dec.src[1] = 2'd3; end
            5'b10001: begin dec.en[2] = 1'b1; dec.src[2] = 2'd0; end
            5'b10010: begin dec.en[3] = 1'b1; dec.src[3] = 2'd1; end
            5'b10011: begin dec.en[2] = 1'b1; dec.src[2] = 2'd0; dec.en[3] = 1'b1; dec.src[3] = 2'd1; end
            5'b10100: begin dec.en[0] = 1'b1; dec.src[0] = 2'd2; dec.en[3] = 1'b1; dec.src[3] = 2'd1; end
            5'b10101: begin dec.en[0] = 1'b1; dec.src[0] = 2'd2; end
            5'b10110: begin dec.en[1] = 1'b1; dec.src[1] = 2'd3; end
            5'b10111: begin dec.en[0] = 1'b1; dec.src[0] = 2'd2; dec.en[1] = 1'b1; dec.src[1] = 2'd3; end
            5'b11000: begin dec.en[0] = 1'b1; dec.src[0] = 2'd3; dec.en[2] = 1'b1; dec.src[2] = 2'd1; end
            5'b11001: begin dec.en[1] = 1'b1; dec.src[1] = 2'd2; end
            5'b11010: begin dec.en[0] = 1'b1; dec.src[0] = 2'd3; end
            5'b11011: begin dec.en[0] = 1'b1; dec.src[0] = 2'd3; dec.en[1] = 1'b1; dec.src[1] = 2'd2; end
            5'b11100: begin dec.en[3] = 1'b1; dec.src[3] = 2'd0; dec.en[1] = 1'b1; dec.src[1] = 2'd2; end
            5'b11101: begin dec.en[3] = 1'b1; dec.src[3] = 2'd0; end
            5'b11110: begin dec.en[2] = 1'b1; dec.src[2] = 2'd1; end
            5'b11111: begin dec.en[3] = 1'b1; dec.src[3] = 2'd0; dec.en[2] = 1'b1; dec.src[2] = 2'd1; end
            default:  dec = '0;
        endcase
    end
endmodule

// File: rtl/xchg_route_fsm.sv
module xchg_route_fsm
    import xchg_pkg::*;
(
    input  logic              clk,
    input  logic              force_off,
    input  logic              data_mode,
    input  logic [CODE_W-1:0] route_sel,
    output route_state_e      state_q,
    output logic [CODE_W-1:0] route_q,
    output logic              active
);
    route_state_e state_d;
    logic         code_valid;

    assign code_valid = |route_sel[CODE_W-1:CODE_W-2];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RT_IDLE: begin
                if (!data_mode && code_valid) state_d = RT_ACTIVE;
            end
            RT_ACTIVE: begin
                if (!data_mode && !code_valid) state_d = RT_IDLE;
            end
            default: state_d = RT_IDLE;
        endcase
    end

    always_ff @(posedge clk or posedge force_off) begin
        if (force_off) begin
            state_q <= RT_IDLE;
            route_q <= '0;
        end else begin
            state_q <= state_d;
            if (!data_mode) route_q <= route_sel;
        end
    end

    always_comb begin
        active = (state_q == RT_ACTIVE);
    end
endmodule

// File: rtl/xchg_port_stage.sv
module xchg_port_stage
    import xchg_pkg::*;
#(
    parameter int W = 9
) (
    input  logic                  clk,
    input  logic                  force_off,
    input  logic                  capture,
    input  logic [SRC_W-1:0]      src_sel,
    input  logic [N_PORT*W-1:0]   bus_in,
    output logic [W-1:0]          data_q
);
    logic [W-1:0] picked;

    always_comb begin
        picked = bus_in[src_sel*W +: W];
    end

    always_ff @(posedge clk or posedge force_off) begin
        if (force_off)    data_q <= '0;
        else if (capture) data_q <= picked;
    end
endmodule

// File: rtl/bus_exchanger4.sv
module bus_exchanger4
    import xchg_pkg::*;
#(
    parameter int W = 9
) (
    input  logic                clk,
    input  logic                force_off,
    input  logic                data_mode,
    input  logic [CODE_W-1:0]   route_sel,
    input  logic [N_PORT*W-1:0] port_in,
    output logic [N_PORT*W-1:0] port_out,
    output logic [N_PORT-1:0]   port_oe
);
    route_state_e      state_q;
    logic [CODE_W-1:0] route_q;
    logic              active;
    route_dec_t        dec;

    xchg_route_fsm u_fsm (
        .clk       (clk),
        .force_off (force_off),
        .data_mode (data_mode),
        .route_sel (route_sel),
        .state_q   (state_q),
        .route_q   (route_q),
        .active    (active)
    );

    xchg_route_decoder u_dec (
        .code (route_q),
        .dec  (dec)
    );

    assign port_oe = dec.en & {N_PORT{active & ~force_off}};

    for (genvar p = 0; p < N_PORT; p++) begin : g_port
        xchg_port_stage #(.W(W)) u_stage (
            .clk       (clk),
            .force_off (force_off),
            .capture   (data_mode & active & dec.en[p]),
            .src_sel   (dec.src[p]),
            .bus_in    (port_in),
            .data_q    (port_out[p*W +: W])
        );
    end
endmodule

// File: rtl/xchg_chk.sv
module xchg_chk
    import xchg_pkg::*;
#(
    parameter int W = 9
) (
    input logic                clk,
    input logic                force_off,
    input logic                data_mode,
    input logic [CODE_W-1:0]   route_sel,
    input logic [N_PORT*W-1:0] port_out,
    input logic [N_PORT-1:0]   port_oe
);
    always_comb begin
        if (force_off) begin
            AST_OFF_NOW: assert (port_oe == '0); // R1
        end
    end

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (force_off) !data_mode |=> $stable(port_out)); // R4

    AST_UNUSED_OFF: assert property (@(posedge clk) disable iff (force_off) (!data_mode && route_sel[CODE_W-1:CODE_W-2] == 2'b00) |=> port_oe == '0); // R6

    AST_REENABLE_LOAD: assert property (@(posedge clk) disable iff (force_off) ($past(force_off) && data_mode) |=> port_oe == '0); // R10

    AST_ROUTE_KEEP: assert property (@(posedge clk) disable iff (force_off) data_mode |=> $stable(port_oe)); // R11

    AST_AT_MOST_TWO: assert property (@(posedge clk) disable iff (force_off) $countones(port_oe) <= 2); // R2
endmodule

bind bus_exchanger4 xchg_chk #(.W(W)) u_chk (
    .clk       (clk),
    .force_off (force_off),
    .data_mode (data_mode),
    .route_sel (route_sel),
    .port_out  (port_out),
    .port_oe   (port_oe)
);

// File: tb/bus_exchanger4_tb_top.sv
module bus_exchanger4_tb_top;
    localparam int W = 9;
    localparam int NP = 4;

    logic            clk = 1'b0;
    logic            force_off = 1'b1;
    logic            data_mode = 1'b1;
    logic [4:0]      route_sel = '0;
    logic [NP*W-1:0] port_in = '0;
    logic [NP*W-1:0] port_out;
    logic [NP-1:0]   port_oe;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [W-1:0] exp_out [NP];
    logic [4:0]   exp_route;
    logic [NP-1:0] exp_oe;

    always #4 clk = ~clk;

    bus_exchanger4 #(.W(W)) dut_i (
        .clk       (clk),
        .force_off (force_off),
        .data_mode (data_mode),
        .route_sel (route_sel),
        .port_in   (port_in),
        .port_out  (port_out),
        .port_oe   (port_oe)
    );

    // {valid0, src0, dst0, valid1, src1, dst1}
    function automatic logic [9:0] ref_xfer(input logic [4:0] c);
        case (c)
            5'b01000: return {1'b1, 2'd1, 2'd0, 1'b1, 2'd2, 2'd3};
            5'b01001: return {1'b1, 2'd1, 2'd0, 5'd0};
            5'b01010: return {1'b1, 2'd3, 2'd2, 5'd0};
            5'b01011: return {1'b1, 2'd1, 2'd0, 1'b1, 2'd3, 2'd2};
            5'b01100: return {1'b1, 2'd0, 2'd1, 1'b1, 2'd2, 2'd3};
            5'b01101: return {1'b1, 2'd0, 2'd1, 5'd0};
            5'b01110: return {1'b1, 2'd2, 2'd3, 5'd0};
            5'b01111: return {1'b1, 2'd0, 2'd1, 1'b1, 2'd3, 2'd2};
            5'b10000: return {1'b1, 2'd0, 2'd2, 1'b1, 2'd3, 2'd1};
            5'b10001: return {1'b1, 2'd0, 2'd2, 5'd0};
            5'b10010: return {1'b1, 2'd1, 2'd3, 5'd0};
            5'b10011: return {1'b1, 2'd0, 2'd2, 1'b1, 2'd1, 2'd3};
            5'b10100: return {1'b1, 2'd2, 2'd0, 1'b1, 2'd1, 2'd3};
            5'b10101: return {1'b1, 2'd2, 2'd0, 5'd0};
            5'b10110: return {1'b1, 2'd3, 2'd1, 5'd0};
            5'b10111: return {1'b1, 2'd2, 2'd0, 1'b1, 2'd3, 2'd1};
            5'b11000: return {1'b1, 2'd3, 2'd0, 1'b1, 2'd1, 2'd2};
            5'b11001: return {1'b1, 2'd2, 2'd1, 5'd0};
            5'b11010: return {1'b1, 2'd3, 2'd0, 5'd0};
            5'b11011: return {1'b1, 2'd3, 2'd0, 1'b1, 2'd2, 2'd1};
            5'b11100: return {1'b1, 2'd0, 2'd3, 1'b1, 2'd2, 2'd1};
            5'b11101: return {1'b1, 2'd0, 2'd3, 5'd0};
            5'b11110: return {1'b1, 2'd1, 2'd2, 5'd0};
            5'b11111: return {1'b1, 2'd0, 2'd3, 1'b1, 2'd1, 2'd2};
            default:  return '0;
        endcase
    endfunction

    function automatic logic [NP-1:0] ref_mask(input logic [4:0] c);
        logic [9:0] x = ref_xfer(c);
        logic [NP-1:0] m = '0;
        if (x[9]) m[x[6:5]] = 1'b1;
        if (x[4]) m[x[1:0]] = 1'b1;
        return m;
    endfunction

    function automatic string grp_req(input logic [4:0] c);
        case (c[4:3])
            2'b00:   return "R6";
            2'b01:   return "R7";
            2'b10:   return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_outs(input string req);
        for (int p = 0; p < NP; p++)
            check(req, 64'(port_out[p*W +: W]), 64'(exp_out[p]));
    endtask

    function automatic logic [NP*W-1:0] pattern(input int c, input int k);
        logic [NP*W-1:0] v;
        for (int p = 0; p < NP; p++)
            v[p*W +: W] = W'((c * 37 + p * 91 + k * 13 + 5) & ((1 << W) - 1));
        return v;
    endfunction

    task automatic model_data_edge();
        logic [9:0] x = ref_xfer(exp_route);
        if (x[9]) exp_out[x[6:5]] = port_in[x[8:7]*W +: W];
        if (x[4]) exp_out[x[1:0]] = port_in[x[3:2]*W +: W];
    endtask

    task automatic load_route(input logic [4:0] c, input int k);
        @(negedge clk);
        data_mode = 1'b0;
        route_sel = c;
        port_in   = pattern(c, k);
        @(posedge clk);
        exp_route = c;
        exp_oe    = ref_mask(c);
        #2;
    endtask

    task automatic data_edge(input int c, input int k);
        @(negedge clk);
        data_mode = 1'b1;
        route_sel = ~exp_route;   // R11: ignored while moving data
        port_in   = pattern(c, k);
        @(posedge clk);
        model_data_edge();
        #2;
    endtask

    initial begin
        for (int p = 0; p < NP; p++) exp_out[p] = '0;
        exp_route = '0;
        exp_oe    = '0;
        #6;
        // R1: reset state under force_off
        check("R1", 64'(port_oe), 64'(0));
        check_outs("R1");
        @(negedge clk);
        force_off = 1'b0;
        port_in = pattern(3, 3);
        @(posedge clk);
        #2;
        // R10: data edge after release does not enable
        check("R10", 64'(port_oe), 64'(0));
        check_outs("R10");

        for (int c = 0; c < 32; c++) begin
            load_route(5'(c), 7);
            // R2 with per-group table
            check(grp_req(5'(c)), 64'(port_oe), 64'(exp_oe));
            check_outs("R4");
            for (int k = 0; k < 2; k++) begin
                data_edge(c, k);
                check("R11", 64'(port_oe), 64'(exp_oe));
                // R3 for destinations, R5 for the rest
                for (int p = 0; p < NP; p++)
                    check(exp_oe[p] ? "R3" : "R5", 64'(port_out[p*W +: W]), 64'(exp_out[p]));
            end
        end

        // R1: asynchronous disable mid-cycle
        load_route(5'b10011, 1);
        check("R2", 64'(port_oe), 64'(4'b1100));
        data_edge(40, 2);
        check_outs("R3");
        @(negedge clk);
        #1;
        force_off = 1'b1;
        #1;
        check("R1", 64'(port_oe), 64'(0));
        for (int p = 0; p < NP; p++) exp_out[p] = '0;
        check_outs("R1");
        @(negedge clk);
        force_off = 1'b0;
        exp_route = '0;
        exp_oe = '0;
        data_edge(41, 0);
        check("R10", 64'(port_oe), 64'(0));
        check_outs("R10");
        load_route(5'b01101, 0);
        check("R10", 64'(port_oe), 64'(4'b0010));
        data_edge(42, 1);
        check("R3", 64'(port_out[1*W +: W]), 64'(pattern(42, 1)[0 +: W]));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule